// File: doc/BRIEF.md
# Serial Register Target with Auto-Incrementing Pointer

This block is a two-wire serial bus target (I2C-style, 7-bit addressing) that gives a bus controller access to a bank of eight byte-wide registers. SCL and SDA are oversampled by a fast system clock through two-flop synchronizers. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The target answers its own 7-bit device address and ignores every other address. SDA is open-drain: the output `sda_oe` pulls the line low when it is 1 and releases it when it is 0.

A write transfer loads its first data byte into a volatile 3-bit pointer. Every following byte goes to the register the pointer selects, and the pointer then steps forward. A read transfer sends the register at the pointer. The pointer moves on only when the controller acknowledges the byte. A controller can set the pointer with a write and then switch to reading with a repeated START. It can also start reading straight away, in which case the read begins wherever the pointer was left. A power-fail input deselects the target, releases SDA and blocks all register writes while it is held.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset SDA is released (`sda_oe` = 0), the pointer is 0 and all eight registers read 0x00.
- R2: The target acknowledges an address byte whose upper 7 bits equal DEV_ADDR (default 0x51; bit 0 = 1 means read). Any other address gets no acknowledge, and the target ignores the bus until the next START or STOP.
- R3: In a write transfer the first byte after the address is acknowledged. Its low 3 bits are loaded into the pointer and no register is written.
- R4: Every later byte of a write is acknowledged and stored at the pointer. The pointer then increments and wraps from 7 to 0.
- R5: In a read the target sends the register at the pointer, MSB first. A controller ACK (SDA low in the ninth clock) advances the pointer, with wrap, and the target sends the next register.
- R6: A controller NACK leaves the pointer unchanged, and SDA stays released until the next START.
- R7: A read that is not preceded by a pointer write in the same transfer starts at the pointer value left by earlier traffic.
- R8: After each sampled SCL falling edge, `sda_oe` keeps its value for HOLD_CYC system clocks before it may change.
- R9: While `pwr_fail` is 1, `sda_oe` is 0 from the following clock, no address is acknowledged and no register is written.
- R10: A START or STOP at any bit position aborts the byte in progress. After a START the next 8 bits are taken as a new address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| pwr_fail | input | 1 | Supply failure: deselect and write-protect |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A corrupted pointer or register shows at the ports in the next read: the first byte returned is wrong, so the fault appears within nine SCL periods of the read address. A wrong state in the bit sequencer shows up as a missing or misplaced acknowledge, or as data shifted by one bit, on the very next byte. A broken hold counter moves `sda_oe` within a few system clocks of a falling SCL edge. A bench monitor catches this on the same edge.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    S_IDLE,   // deselected, waiting for START
    S_ADDR,   // shifting in device address
    S_AACK,   // driving ACK for address
    S_WRX,    // shifting in a write byte
    S_WACK,   // driving ACK for write byte
    S_TX,     // shifting out a read byte
    S_TACK    // sampling controller ACK/NACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta;
    logic stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= 1'b1;
        stab <= 1'b1;
      end else begin
        meta <= d_i[g];
        stab <= meta;
      end
    end
    assign q_o[g] = stab;
  end
endmodule

// File: rtl/i2c_tgt_events.sv
module i2c_tgt_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  a_r10_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({scl_rise, scl_fall, start_c, stop_c}) <= 1);
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DEPTH-1:0][DW-1:0] mem;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic sel;
    assign sel = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= '0;
      else if (sel) mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R4: contents change only in a cycle that follows a write strobe
  a_r4_store_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> (mem == $past(mem)));
endmodule

// File: rtl/i2c_tgt_drive.sv
module i2c_tgt_drive #(
  parameter int HOLD_CYC = 4,
  localparam int HC_W    = $clog2(HOLD_CYC + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_fall,
  input  logic want_low,
  input  logic force_rel,
  output logic sda_oe
);
  logic [HC_W-1:0] hcnt, hcnt_n;
  logic            oe_n;

  always_comb begin
    hcnt_n = hcnt;
    oe_n   = sda_oe;
    if (force_rel) begin
      hcnt_n = '0;
      oe_n   = 1'b0;
    end else if (scl_fall) begin
      hcnt_n = HC_W'(HOLD_CYC);
    end else if (hcnt != '0) begin
      hcnt_n = hcnt - 1'b1;
    end else begin
      oe_n = want_low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= '0;
      sda_oe <= 1'b0;
    end else begin
      hcnt   <= hcnt_n;
      sda_oe <= oe_n;
    end
  end

  a_r9_release_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_rel) |-> !sda_oe);
  a_r8_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && !force_rel) |=> $stable(sda_oe));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h51,
  parameter int DEPTH    = 8,
  parameter int DW       = 8,
  parameter int HOLD_CYC = 4,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic pwr_fail,
  output logic sda_oe
);
  import i2c_tgt_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

  i2c_tgt_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_q), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s}));

  i2c_tgt_events u_evt (
    .clk(clk), .rst_n(rst_q), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c));

  tgt_state_e       state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [DW-1:0]    sh, sh_n;
  logic [PTR_W-1:0] ptr, ptr_n, raddr;
  logic             first, first_n, rw, rw_n, ack_seen, ack_n;
  logic             we, ptr_load, want_low;
  logic [DW-1:0]    rdata;

  assign raddr = (state == S_TACK) ? ptr + PTR_W'(1) : ptr;

  i2c_tgt_regs #(.DEPTH(DEPTH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_q), .we(we), .waddr(ptr), .wdata(sh),
    .raddr(raddr), .rdata(rdata));

  always_comb begin
    state_n  = state;
    cnt_n    = cnt;
    sh_n     = sh;
    ptr_n    = ptr;
    first_n  = first;
    rw_n     = rw;
    ack_n    = ack_seen;
    we       = 1'b0;
    ptr_load = 1'b0;
    if (pwr_fail) begin
      state_n = S_IDLE;
    end else if (start_c) begin
      state_n = S_ADDR;
      cnt_n   = '0;
      first_n = 1'b1;
    end else if (stop_c) begin
      state_n = S_IDLE;
    end else begin
      unique case (state)
        S_ADDR, S_WRX: begin
          if (scl_rise && cnt != CNT_W'(DW)) begin
            sh_n  = {sh[DW-2:0], sda_s};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_W'(DW)) begin
            cnt_n = '0;
            if (state == S_WRX) begin
              state_n = S_WACK;
            end else if (sh[DW-1:DW-7] == DEV_ADDR) begin
              state_n = S_AACK;
              rw_n    = sh[0];
            end else begin
              state_n = S_IDLE;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw) begin
              state_n = S_TX;
              sh_n    = rdata;
            end else begin
              state_n = S_WRX;
            end
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            state_n = S_WRX;
            if (first) begin
              ptr_n    = sh[PTR_W-1:0];
              first_n  = 1'b0;
              ptr_load = 1'b1;
            end else begin
              we    = 1'b1;
              ptr_n = ptr + PTR_W'(1);
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt == CNT_W'(DW - 1)) begin
              state_n = S_TACK;
              cnt_n   = '0;
            end else begin
              sh_n  = {sh[DW-2:0], 1'b0};
              cnt_n = cnt + 1'b1;
            end
          end
        end
        S_TACK: begin
          if (scl_rise) begin
            ack_n = ~sda_s;
          end else if (scl_fall) begin
            if (ack_seen) begin
              ptr_n   = ptr + PTR_W'(1);
              sh_n    = rdata;
              state_n = S_TX;
            end else begin
              state_n = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state    <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      ptr      <= '0;
      first    <= 1'b0;
      rw       <= 1'b0;
      ack_seen <= 1'b0;
    end else begin
      state    <= state_n;
      cnt      <= cnt_n;
      sh       <= sh_n;
      ptr      <= ptr_n;
      first    <= first_n;
      rw       <= rw_n;
      ack_seen <= ack_n;
    end
  end

  assign want_low = (state == S_AACK) || (state == S_WACK) ||
                    ((state == S_TX) && !sh[DW-1]);

  i2c_tgt_drive #(.HOLD_CYC(HOLD_CYC)) u_drv (
    .clk(clk), .rst_n(rst_q), .scl_fall(scl_fall), .want_low(want_low),
    .force_rel(pwr_fail), .sda_oe(sda_oe));

  // R4/R5: without a pointer load the pointer holds or steps by one
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_q)
    !$past(ptr_load) |-> (ptr == $past(ptr) || ptr == PTR_W'($past(ptr) + 1'b1)));
  a_r6_nack_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_q)
    (state == S_TACK && scl_fall && !ack_seen) |=> $stable(ptr));
  a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_q)
    (start_c && !pwr_fail) |=> (state == S_ADDR && cnt == '0));
  a_r9_no_write_in_fail: assert property (@(posedge clk) disable iff (!rst_q)
    $past(pwr_fail) |-> (state == S_IDLE));
endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int HOLD       = 4;
  localparam logic [6:0] DEV = 7'h51;
  localparam int WDOG       = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_tb = 1'b1;
  logic sda_tb = 1'b1;
  logic pwr_fail = 1'b0;
  logic sda_oe;
  wire  sda_bus = sda_tb & ~sda_oe;

  int errors = 0;
  int checks = 0;
  int hold_viol = 0;

  logic [7:0] m_mem [8];
  logic [2:0] m_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_target #(.DEV_ADDR(DEV), .HOLD_CYC(HOLD)) i_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_tb), .sda_i(sda_bus),
    .pwr_fail(pwr_fail), .sda_oe(sda_oe));

  // R8 monitor: no change of sda_oe shortly after the bench drops SCL
  int   age = 1000;
  logic scl_prev = 1'b1;
  logic oe_prev  = 1'b0;
  always @(negedge clk) begin
    if (scl_prev && !scl_tb) age = 0;
    else if (age < 1000) age = age + 1;
    if (rst_n && !pwr_fail && sda_oe !== oe_prev && age <= HOLD + 2)
      hold_viol = hold_viol + 1;
    scl_prev = scl_tb;
    oe_prev  = sda_oe;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    tick(Q); sda_tb = b;
    tick(Q); scl_tb = 1'b1;
    tick(Q); s = sda_bus;
    tick(Q); scl_tb = 1'b0;
  endtask

  task automatic do_start();
    if (!scl_tb) begin
      tick(Q); sda_tb = 1'b1;
      tick(Q); scl_tb = 1'b1;
      tick(Q);
    end
    sda_tb = 1'b0;
    tick(Q); scl_tb = 1'b0;
  endtask

  task automatic do_stop();
    tick(Q); sda_tb = 1'b0;
    tick(Q); scl_tb = 1'b1;
    tick(Q); sda_tb = 1'b1;
    tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      b[i] = s;
    end
    bit_xfer(~ack, s);
  endtask

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction

  task automatic wr_txn(input logic [2:0] p, input int n);
    logic ack;
    logic [7:0] d;
    do_start();
    send_byte(addr_byte(DEV, 1'b0), ack);
    check(ack, "R2 address ack (write)", ack, 1);
    send_byte({$urandom_range(0, 31), p}, ack);
    check(ack, "R3 pointer byte ack", ack, 1);
    m_ptr = p;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack);
      check(ack, "R4 data byte ack", ack, 1);
      m_mem[m_ptr] = d;
      m_ptr = m_ptr + 3'd1;
    end
    do_stop();
  endtask

  task automatic rd_txn(input logic set_ptr, input logic [2:0] p, input int n);
    logic ack;
    logic [7:0] d;
    do_start();
    if (set_ptr) begin
      send_byte(addr_byte(DEV, 1'b0), ack);
      send_byte({5'b0, p}, ack);
      m_ptr = p;
      do_start();
    end
    send_byte(addr_byte(DEV, 1'b1), ack);
    check(ack, "R2 address ack (read)", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      if (i == 0 && !set_ptr)
        check(d == m_mem[m_ptr], "R7 current-address read", d, m_mem[m_ptr]);
      else
        check(d == m_mem[m_ptr], "R5 sequential read", d, m_mem[m_ptr]);
      if (i < n - 1) m_ptr = m_ptr + 3'd1;
    end
    tick(Q);
    check(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
    do_stop();
  endtask

  task automatic wrong_addr_txn();
    logic ack;
    logic [6:0] a;
    a = 7'($urandom);
    if (a == DEV) a = a ^ 7'h01;
    do_start();
    send_byte(addr_byte(a, 1'b0), ack);
    check(!ack, "R2 foreign address not acked", ack, 0);
    send_byte(8'h00, ack);
    send_byte(8'hA5, ack);
    check(!ack, "R2 foreign traffic ignored", ack, 0);
    do_stop();
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 8; i++) m_mem[i] = 8'h00;
    m_ptr = 3'd0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);
    rd_txn(1'b0, 3'd0, 8);                  // R1: pointer 0, all zeros

    wr_txn(3'd6, 3);                        // R4: wrap 7 -> 0
    rd_txn(1'b1, 3'd6, 4);                  // R5: wrapped read
    rd_txn(1'b0, 3'd0, 2);                  // R6/R7: resumes at NACKed byte

    wrong_addr_txn();                       // R2
    rd_txn(1'b0, 3'd0, 1);

    begin : fail_write                      // R9
      logic ack;
      pwr_fail = 1'b1;
      tick(2);
      check(sda_oe == 1'b0, "R9 released in power fail", sda_oe, 0);
      do_start();
      send_byte(addr_byte(DEV, 1'b0), ack);
      check(!ack, "R9 no address ack in power fail", ack, 0);
      send_byte(8'h02, ack);
      send_byte(8'hEE, ack);
      do_stop();
      pwr_fail = 1'b0;
      tick(Q);
      rd_txn(1'b1, 3'd2, 2);                // memory unchanged
    end

    begin : fail_mid_read                   // R9 while driving
      logic ack;
      logic s;
      do_start();
      send_byte(addr_byte(DEV, 1'b1), ack);
      for (int i = 0; i < 3; i++) bit_xfer(1'b1, s);
      pwr_fail = 1'b1;
      tick(2);
      check(sda_oe == 1'b0, "R9 release mid-read", sda_oe, 0);
      do_stop();
      pwr_fail = 1'b0;
      tick(Q);
      rd_txn(1'b0, 3'd0, 1);                // pointer untouched
    end

    begin : abort_stop                      // R10: STOP mid-byte
      logic ack;
      logic s;
      do_start();
      send_byte(addr_byte(DEV, 1'b0), ack);
      send_byte(8'h05, ack);
      m_ptr = 3'd5;
      for (int i = 0; i < 4; i++) bit_xfer(1'b0, s);
      do_stop();
      rd_txn(1'b0, 3'd0, 1);
    end

    begin : abort_rstart                    // R10: repeated START mid-byte
      logic ack;
      logic s;
      logic [7:0] d;
      do_start();
      send_byte(addr_byte(DEV, 1'b0), ack);
      send_byte(8'h03, ack);
      m_ptr = 3'd3;
      for (int i = 0; i < 3; i++) bit_xfer(1'b1, s);
      do_start();
      send_byte(addr_byte(DEV, 1'b1), ack);
      check(ack, "R10 address after restart", ack, 1);
      recv_byte(1'b0, d);
      check(d == m_mem[3], "R10 no write from aborted byte", d, m_mem[3]);
      do_stop();
    end

    for (int it = 0; it < 24; it++) begin
      case ($urandom_range(0, 3))
        0: wr_txn(3'($urandom), $urandom_range(1, 4));
        1: rd_txn(1'b1, 3'($urandom), $urandom_range(1, 4));
        2: rd_txn(1'b0, 3'd0, $urandom_range(1, 3));
        default: wrong_addr_txn();
      endcase
    end

    check(hold_viol == 0, "R8 hold after SCL fall", hold_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule